// File: doc/BRIEF.md
# Serial EEPROM Read Engine (I2C Target)

This block is a two-wire bus target that behaves like a 256-byte serial EEPROM whose strength is reading. It holds a single address pointer that lasts from one transaction to the next. A controller can read from wherever that pointer currently stands. It can also aim the pointer first, by sending a short write that carries only a word address, and then issue a repeated start with the read bit set. When it acknowledges each byte, the block keeps streaming bytes from successive locations.

Both bus lines are open-drain. SCL is only an input. SDA appears as an input sample plus a drive-low enable, and the surrounding pad logic turns that enable into a pull to ground. Everything inside runs on the system clock. Both lines pass through synchronisers, and start and stop are found from edges of those synchronised samples. Byte writes update the storage array and the pointer. The block has no write-cycle delay, no page buffer and no write lock.

Top module: `seeprom_target`

## Requirements
- R1: After reset, `sdaLow` is 0, the pointer is 0 and every storage byte is 0x00.
- R2: An address byte is sent MSB first: seven address bits, then the R/W bit (1 = read). The target acknowledges only when the seven bits equal `DEV_ADDR`, by holding SDA low through the ninth clock. A mismatched address gets no acknowledge. Bytes that follow it, up to the next start, neither change the storage nor drive SDA.
- R3: In a write (R/W = 0), the first byte after the address loads the pointer. Each further byte is stored at the pointer, acknowledged, and moves the pointer on by one, wrapping from 255 to 0. A stop right after the word address leaves the pointer loaded and the storage untouched.
- R4: Every data byte sent by the target comes MSB first from the location at the pointer, and the pointer then advances by one.
- R5: A read with no word address returns the location one past the byte last read or written. After an access at 255 it returns location 0.
- R6: A word-address write followed by a repeated start with R/W = 1 returns the byte at that word address.
- R7: When the controller pulls SDA low in the slot after a data byte, the target sends the next location. Output carries on from 255 to 0 without a break.
- R8: When SDA is high in the slot after a data byte, the target stops sending, releases SDA and ignores further clocks until a start or stop. The pointer then stands one past the last byte sent.
- R9: The target changes SDA only while SCL is low. It leaves SDA released during every bit the controller drives.
- R10: A start or stop at any bit position drops the partial byte. A start resumes address matching, and a stop returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sdaLow | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench goes after the points where the pointer has to wrap. It writes a run that crosses 255, streams six bytes across the same boundary, and reads from the current address right after touching 255. A design that saturated or reset the pointer there would return the wrong bytes. It checks the pointer-only write, where a design that stored the next byte anyway, or ignored the loaded address, would corrupt storage or read from the wrong place. It also checks abandoned bytes (a stop or start partway through a byte) and a mismatched address. A target that still acknowledged, or stored a byte, or went on driving SDA after a NACK, would show up as a wrong acknowledge bit, a changed location, or a bus that reads low while the controller expects it to be released.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_ACKDEV,
    S_WORD,
    S_ACKWORD,
    S_WDATA,
    S_ACKDATA,
    S_TX,
    S_TXACK
  } ctrlState_t;

  // strobes from the controller to the datapath; at most one per cycle
  typedef struct packed {
    logic shiftIn;   // take one received bit
    logic loadPtr;   // pointer <= received byte
    logic writeMem;  // store received byte at pointer, advance pointer
    logic loadTx;    // fetch byte at pointer into transmit register, advance
    logic shiftTx;   // move next transmit bit to the front
  } dpStrobe_t;

endpackage

// File: rtl/seeprom_sync.sv
module seeprom_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sclPipe;
  logic [MSB:0] sdaPipe;
  logic         sclQ;
  logic         sdaQ;
  logic         sclS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[MSB-1:0], sclIn};
      sdaPipe <= {sdaPipe[MSB-1:0], sdaIn};
      sclQ    <= sclPipe[MSB];
      sdaQ    <= sdaPipe[MSB];
    end
  end

  assign sclS     = sclPipe[MSB];
  assign sdaS     = sdaPipe[MSB];
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

endmodule

// File: rtl/seeprom_dp.sv
module seeprom_dp
  import seeprom_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaS,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      ptr     <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[DATA_W-2:0], sdaS};
      if (stb.loadPtr) ptr <= rxShift[ADDR_W-1:0];
      if (stb.writeMem) begin
        mem[ptr] <= rxShift;
        ptr      <= ptr + 1'b1;
      end
      if (stb.loadTx) begin
        txShift <= mem[ptr];
        ptr     <= ptr + 1'b1;
      end
      if (stb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b1};
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[DATA_W-1];

endmodule

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
  import seeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         stb,
  output logic              sdaLow
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  ctrlState_t       st, stNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             ackSeen, ackNxt;

  always_comb begin
    stNxt  = st;
    cntNxt = cnt;
    ackNxt = ackSeen;
    stb    = '0;
    if (startDet) begin
      stNxt  = S_DEV;
      cntNxt = '0;
    end else if (stopDet) begin
      stNxt  = S_IDLE;
      cntNxt = '0;
    end else begin
      case (st)
        S_DEV, S_WORD, S_WDATA: begin
          if (sclRise && cnt != CNT_FULL) begin
            stb.shiftIn = 1'b1;
            cntNxt      = cnt + 1'b1;
          end else if (sclFall && cnt == CNT_FULL) begin
            cntNxt = '0;
            if (st == S_DEV) begin
              stNxt = (rxByte[DATA_W-1:1] == DEV_ADDR) ? S_ACKDEV : S_IDLE;
            end else if (st == S_WORD) begin
              stb.loadPtr = 1'b1;
              stNxt       = S_ACKWORD;
            end else begin
              stb.writeMem = 1'b1;
              stNxt        = S_ACKDATA;
            end
          end
        end
        S_ACKDEV: begin
          if (sclFall) begin
            if (rxByte[0]) begin
              stb.loadTx = 1'b1;
              stNxt      = S_TX;
            end else begin
              stNxt = S_WORD;
            end
          end
        end
        S_ACKWORD, S_ACKDATA: begin
          if (sclFall) stNxt = S_WDATA;
        end
        S_TX: begin
          if (sclFall) begin
            stb.shiftTx = 1'b1;
            if (cnt == CNT_LAST) begin
              cntNxt = '0;
              stNxt  = S_TXACK;
            end else begin
              cntNxt = cnt + 1'b1;
            end
          end
        end
        S_TXACK: begin
          if (sclRise) begin
            ackNxt = ~sdaS;
          end else if (sclFall) begin
            if (ackSeen) begin
              stb.loadTx = 1'b1;
              stNxt      = S_TX;
            end else begin
              stNxt = S_IDLE;
            end
          end
        end
        default: stNxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      cnt     <= '0;
      ackSeen <= 1'b0;
    end else begin
      st      <= stNxt;
      cnt     <= cntNxt;
      ackSeen <= ackNxt;
    end
  end

  always_comb begin
    case (st)
      S_ACKDEV, S_ACKWORD, S_ACKDATA: sdaLow = 1'b1;
      S_TX:                           sdaLow = ~txBit;
      default:                        sdaLow = 1'b0;
    endcase
  end

endmodule

// File: rtl/seeprom_target.sv
module seeprom_target
  import seeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLow
);

  logic              sdaS;
  logic              sclRise;
  logic              sclFall;
  logic              startDet;
  logic              stopDet;
  logic [DATA_W-1:0] rxByte;
  logic              txBit;
  dpStrobe_t         stb;

  seeprom_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sdaS     (sdaS),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet)
  );

  seeprom_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sdaS     (sdaS),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .stb      (stb),
    .sdaLow   (sdaLow)
  );

  seeprom_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .sdaS   (sdaS),
    .rxByte (rxByte),
    .txBit  (txBit)
  );

endmodule

// File: rtl/seeprom_target_chk.sv
module seeprom_target_chk
  import seeprom_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclIn,
  input logic      sdaLow,
  input logic      startDet,
  input logic      stopDet,
  input dpStrobe_t stb
);

  // R9: no change of the drive while the clock line stays high
  a_r9_hold_while_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaLow));

  // R10: a stop leaves the data line released
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaLow);

  // R10: a start leaves the data line released for address matching
  a_r10_start_releases: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaLow);

  // R4: the controller issues at most one datapath action per cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R3: a store is never paired with a fetch in the following cycle
  a_r3_store_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeMem |=> !stb.loadTx);

endmodule

bind seeprom_target seeprom_target_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .sdaLow   (sdaLow),
  .startDet (startDet),
  .stopDet  (stopDet),
  .stb      (stb)
);

// File: tb/seeprom_target_tb.sv
module seeprom_target_tb;

  localparam logic [6:0] DEV = 7'h50;
  localparam int HALF = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic sclIn;
  logic mLow;
  logic sdaLow;
  wire  sdaBus = ~(mLow | sdaLow);

  seeprom_target #(.DEV_ADDR(DEV)) u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaBus),
    .sdaLow (sdaLow)
  );

  int checks = 0;
  int errors = 0;
  int refMem [256];
  int refPtr = 0;
  logic expQuiet = 1'b0;
  int quietViol = 0;
  bit finished = 1'b0;

  // per-clock model comparison: target must stay off the bus during controller bits
  always @(negedge clk) if (expQuiet && sdaLow) quietViol++;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkQuiet();
    check("R9 released during controller bits", quietViol, 0);
    quietViol = 0;
  endtask

  task automatic i2cStart();
    mLow = 1'b0; wt(HALF/2);
    sclIn = 1'b1; wt(HALF);
    mLow = 1'b1; wt(HALF);
    sclIn = 1'b0; wt(HALF/2);
  endtask

  task automatic i2cStop();
    mLow = 1'b1; wt(HALF/2);
    sclIn = 1'b1; wt(HALF);
    mLow = 1'b0; wt(HALF);
  endtask

  task automatic sendBits(input logic [7:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      wt(5);
      mLow = ~val[i];
      expQuiet = 1'b1;
      wt(HALF - 5);
      sclIn = 1'b1; wt(HALF);
      sclIn = 1'b0;
    end
    expQuiet = 1'b0;
  endtask

  task automatic getAck(output bit ack);
    wt(5); mLow = 1'b0; wt(HALF - 5);
    sclIn = 1'b1; wt(HALF/2);
    ack = ~sdaBus;
    wt(HALF/2);
    sclIn = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] val, output bit ack);
    sendBits(val, 8);
    getAck(ack);
  endtask

  task automatic readByte(input bit ackIt, output int val);
    logic [7:0] b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(5); mLow = 1'b0; wt(HALF - 5);
      sclIn = 1'b1; wt(HALF/2);
      b = {b[6:0], sdaBus};
      wt(HALF/2);
      sclIn = 1'b0;
    end
    wt(5); mLow = ackIt; expQuiet = 1'b1; wt(HALF - 5);
    sclIn = 1'b1; wt(HALF);
    sclIn = 1'b0;
    expQuiet = 1'b0;
    val = int'(b);
  endtask

  task automatic memWrite(input int addr, input int n, input int seed);
    bit ack;
    i2cStart();
    writeByte({DEV, 1'b0}, ack); check("R2 write address ack", ack, 1);
    writeByte(addr[7:0], ack);   check("R3 word address ack", ack, 1);
    refPtr = addr;
    for (int i = 0; i < n; i++) begin
      int d = (seed + 37 * i) & 255;
      writeByte(d[7:0], ack);    check("R3 data ack", ack, 1);
      refMem[refPtr] = d;
      refPtr = (refPtr + 1) % 256;
    end
    i2cStop();
    checkQuiet();
  endtask

  task automatic readRun(input string req, input int n);
    int v;
    for (int i = 0; i < n; i++) begin
      readByte(i < n - 1, v);
      check(req, v, refMem[refPtr]);
      refPtr = (refPtr + 1) % 256;
    end
    i2cStop();
    checkQuiet();
  endtask

  task automatic curRead(input string req, input int n);
    bit ack;
    i2cStart();
    writeByte({DEV, 1'b1}, ack); check("R2 read address ack", ack, 1);
    readRun(req, n);
  endtask

  task automatic randRead(input string req, input int addr, input int n);
    bit ack;
    i2cStart();
    writeByte({DEV, 1'b0}, ack); check("R6 dummy write ack", ack, 1);
    writeByte(addr[7:0], ack);   check("R6 word address ack", ack, 1);
    refPtr = addr;
    i2cStart();
    writeByte({DEV, 1'b1}, ack); check("R6 read address ack", ack, 1);
    readRun(req, n);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    int v;
    for (int i = 0; i < 256; i++) refMem[i] = 0;
    rstN = 1'b0; sclIn = 1'b1; mLow = 1'b0;
    wt(10);
    check("R1 reset drive", int'(sdaLow), 0);
    rstN = 1'b1;
    wt(10);
    check("R1 idle drive", int'(sdaLow), 0);

    // R1: pointer and storage start at zero
    curRead("R1 first read location 0", 2);

    // R3, R4, R5: write a run then read around it
    memWrite(8'h10, 3, 8'hA1);
    curRead("R5 read after write", 1);
    randRead("R6 random read", 8'h10, 1);
    curRead("R5 current after random", 2);

    // R3: write wrapping 255 -> 0
    memWrite(8'hFE, 3, 8'h5C);
    // R7: sequential across the boundary
    randRead("R7 sequential wrap", 8'hFC, 6);
    // R5: after access at 255 the next current read is location 0
    randRead("R6 read at 255", 8'hFF, 1);
    curRead("R5 wrap to 0", 1);

    // R3: pointer-only write
    i2cStart();
    writeByte({DEV, 1'b0}, ack); check("R3 ptr-only address ack", ack, 1);
    writeByte(8'h11, ack);       check("R3 ptr-only word ack", ack, 1);
    i2cStop();
    refPtr = 8'h11;
    curRead("R3 pointer-only load", 1);

    // R2: mismatched address in write direction
    i2cStart();
    writeByte({DEV ^ 7'h01, 1'b0}, ack); check("R2 mismatch no ack", ack, 0);
    writeByte(8'h20, ack);               check("R2 ignored byte no ack", ack, 0);
    writeByte(8'h99, ack);               check("R2 ignored data no ack", ack, 0);
    i2cStop();
    curRead("R2 pointer untouched", 1);
    randRead("R2 storage untouched", 8'h20, 1);

    // R2: mismatched address in read direction
    i2cStart();
    writeByte({DEV ^ 7'h02, 1'b1}, ack); check("R2 mismatch read no ack", ack, 0);
    readByte(1'b0, v);                   check("R2 mismatch bus released", v, 8'hFF);
    i2cStop();

    // R8: NACK ends output; further clocks ignored; pointer one past last byte
    i2cStart();
    writeByte({DEV, 1'b1}, ack); check("R8 address ack", ack, 1);
    readByte(1'b0, v);           check("R8 byte before nack", v, refMem[refPtr]);
    refPtr = (refPtr + 1) % 256;
    readByte(1'b0, v);           check("R8 released after nack", v, 8'hFF);
    i2cStop();
    curRead("R8 pointer after nack", 1);

    // R10: stop in the middle of a data byte drops it
    memWrite(8'h30, 1, 8'h77);
    i2cStart();
    writeByte({DEV, 1'b0}, ack); check("R10 address ack", ack, 1);
    writeByte(8'h30, ack);       check("R10 word ack", ack, 1);
    sendBits(8'h0E, 4);
    i2cStop();
    refPtr = 8'h30;
    curRead("R10 partial byte not stored", 1);

    // R10: start in the middle of a byte returns to address matching
    i2cStart();
    writeByte({DEV, 1'b0}, ack); check("R10 address ack 2", ack, 1);
    writeByte(8'h12, ack);       check("R10 word ack 2", ack, 1);
    sendBits(8'h05, 3);
    refPtr = 8'h12;
    i2cStart();
    writeByte({DEV, 1'b1}, ack); check("R10 restart read ack", ack, 1);
    readRun("R10 read after abort", 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule